// File: doc/BRIEF.md
# External Processor Bus to Memory-Mapped Master Bridge

This block lets an external processor reach the on-chip memory-mapped fabric through its own synchronous parallel bus. The processor presents active-low read and write strobes, an active-low select, a word address, per-lane byte enables and an active-low output enable. The data path is one bidirectional pin bus. The bridge turns each strobe into exactly one fabric read or write command. It widens the word address into a byte address and returns the fabric's stall indication to the processor as a ready signal.

Everything runs on the processor's bus reference clock. A command is registered when a strobe is seen and held steady until the fabric stops stalling. The command is removed one cycle after that. The bridge then waits for the strobe to be released before it accepts another access. Read data is latched when the transfer completes. It is driven onto the pins whenever the processor asserts its output enable.

Top module: `ext_cpu_bridge`

## Requirements
- R1: `fab_addr` equals the processor word address shifted left by log2(DATA_W/8) bits, with the appended low bits zero (2 bits for 32-bit data, 1 bit for 16-bit data).
- R2: `fab_byteen` carries the processor byte enables unchanged, one bit per byte lane, with bit 0 for bits 7:0.
- R3: `fab_write` is raised only after a cycle in which `cpu_sel_n` and `cpu_wr_n` were both low. `fab_read` is raised only after a cycle in which `cpu_sel_n` and `cpu_rd_n` were both low.
- R4: `cpu_ready` is the inverse of `fab_waitreq` in every cycle.
- R5: While `cpu_oe_n` is high the bridge leaves `cpu_data` undriven, and the value found there when a write is issued becomes `fab_wdata`.
- R6: No timeout exists. A command stays asserted for as long as `fab_waitreq` stays high.
- R7: While a command is asserted and `fab_waitreq` is high, the address, byte enables, write data and command type do not change.
- R8: The command is deasserted in the cycle after the first clock edge at which `fab_waitreq` is low.
- R9: Each strobe assertion produces exactly one fabric transaction. No new command starts until the strobe is released.
- R10: When read and write strobes are both low with the select low, no command is issued.
- R11: Read data present on `fab_rdata` at completion is captured and is driven on `cpu_data` whenever `cpu_oe_n` is low, until the next read completes.
- R12: DATA_W and the word-address width are parameters. DATA_W must be 8, 16, 32 or 64, and the byte-address width is derived from both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus reference clock |
| rst_n | input | 1 | Active-low reset |
| cpu_sel_n | input | 1 | Processor select, active low |
| cpu_rd_n | input | 1 | Read strobe, active low |
| cpu_wr_n | input | 1 | Write strobe, active low |
| cpu_oe_n | input | 1 | Output enable for read data, active low |
| cpu_addr | input | WORD_AW | Processor word address |
| cpu_be | input | DATA_W/8 | Processor byte enables, active high |
| cpu_data | inout | DATA_W | Shared data pins |
| cpu_ready | output | 1 | High when the fabric is not stalling |
| fab_addr | output | WORD_AW+log2(DATA_W/8) | Fabric byte address |
| fab_byteen | output | DATA_W/8 | Fabric byte enables |
| fab_read | output | 1 | Fabric read command |
| fab_write | output | 1 | Fabric write command |
| fab_wdata | output | DATA_W | Fabric write data |
| fab_rdata | input | DATA_W | Fabric read data |
| fab_waitreq | input | 1 | Fabric stall request |

## Verification
The two functions that can fall in one cycle are ending a transfer and the processor keeping its strobe held. The cycle that drops the command because the stall has ended is also a cycle in which the strobe is still low, and a faulty sequencer would start a second command there. The bench holds each strobe for two further cycles after completion, with a random stall length before it. It expects the command low in every one of those cycles and the captured read data on the pins. A separate directed case drives both strobes at once and expects no command at all.

// File: rtl/xbr_pkg.sv
package xbr_pkg;
   typedef enum logic [1:0] {
      XB_IDLE = 2'd0,
      XB_BUSY = 2'd1,
      XB_HOLD = 2'd2
   } xb_state_t;

   function automatic int lane_shift(input int dw);
      return $clog2(dw / 8);
   endfunction
endpackage

// File: rtl/xbr_addr_map.sv
module xbr_addr_map #(
   parameter int WORD_AW = 22,
   parameter int SHIFT   = 2,
   localparam int BYTE_AW = WORD_AW + SHIFT
) (
   input  logic [WORD_AW-1:0] word_addr,
   output logic [BYTE_AW-1:0] byte_addr
);
   generate
      if (SHIFT == 0) begin : g_same
         assign byte_addr = word_addr;
      end else begin : g_widen
         assign byte_addr = {word_addr, {SHIFT{1'b0}}};
      end
   endgenerate
endmodule

// File: rtl/xbr_data_pad.sv
module xbr_data_pad #(
   parameter int DATA_W = 32
) (
   inout  wire  [DATA_W-1:0] pins,
   input  logic              oe_n,
   input  logic [DATA_W-1:0] drive_val,
   output logic [DATA_W-1:0] sampled
);
   assign pins    = oe_n ? {DATA_W{1'bz}} : drive_val;
   assign sampled = pins;
endmodule

// File: rtl/xbr_cmd_seq.sv
module xbr_cmd_seq
   import xbr_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int BYTE_AW = 24,
   localparam int BE_W   = DATA_W / 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sel,
   input  logic               rd,
   input  logic               wr,
   input  logic [BYTE_AW-1:0] addr_in,
   input  logic [BE_W-1:0]    be_in,
   input  logic [DATA_W-1:0]  wdata_in,
   input  logic               waitreq,
   input  logic [DATA_W-1:0]  rdata_in,
   output logic [BYTE_AW-1:0] m_addr,
   output logic [BE_W-1:0]    m_be,
   output logic               m_rd,
   output logic               m_wr,
   output logic [DATA_W-1:0]  m_wdata,
   output logic [DATA_W-1:0]  rdata_q
);
   xb_state_t state_q;
   logic      lone_rd, lone_wr, released, finish;

   assign lone_rd  = sel && rd && !wr;
   assign lone_wr  = sel && wr && !rd;
   assign released = !sel || (!rd && !wr);
   assign finish   = (state_q == XB_BUSY) && !waitreq;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= XB_IDLE;
         m_rd    <= 1'b0;
         m_wr    <= 1'b0;
         m_addr  <= '0;
         m_be    <= '0;
         m_wdata <= '0;
      end else begin
         unique case (state_q)
            XB_IDLE: begin
               if (lone_rd || lone_wr) begin
                  state_q <= XB_BUSY;
                  m_rd    <= lone_rd;
                  m_wr    <= lone_wr;
                  m_addr  <= addr_in;
                  m_be    <= be_in;
                  m_wdata <= wdata_in;
               end
            end
            XB_BUSY: begin
               if (!waitreq) begin
                  state_q <= XB_HOLD;
                  m_rd    <= 1'b0;
                  m_wr    <= 1'b0;
               end
            end
            XB_HOLD: begin
               if (released) state_q <= XB_IDLE;
            end
            default: state_q <= XB_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 rdata_q <= '0;
      else if (finish && m_rd)    rdata_q <= rdata_in;
   end

   // R3
   wr_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(m_wr) |-> $past(sel && wr));
   // R3
   rd_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(m_rd) |-> $past(sel && rd));
   // R3
   one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(m_rd && m_wr));
   // R7
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (m_rd || m_wr) && waitreq |=>
         $stable(m_addr) && $stable(m_be) && $stable(m_wdata) && $stable(m_rd) && $stable(m_wr));
   // R6
   no_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (m_rd || m_wr) && waitreq |=> (m_rd || m_wr));
   // R8
   drop_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (m_rd || m_wr) && !waitreq |=> !m_rd && !m_wr);
   // R9
   single_txn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == XB_HOLD) && !released |=> !m_rd && !m_wr);
   // R10
   clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == XB_IDLE) && sel && rd && wr |=> !m_rd && !m_wr);
endmodule

// File: rtl/ext_cpu_bridge.sv
module ext_cpu_bridge
   import xbr_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int WORD_AW = 22,
   localparam int BE_W    = DATA_W / 8,
   localparam int SHIFT   = lane_shift(DATA_W),
   localparam int BYTE_AW = WORD_AW + SHIFT
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cpu_sel_n,
   input  logic               cpu_rd_n,
   input  logic               cpu_wr_n,
   input  logic               cpu_oe_n,
   input  logic [WORD_AW-1:0] cpu_addr,
   input  logic [BE_W-1:0]    cpu_be,
   inout  wire  [DATA_W-1:0]  cpu_data,
   output logic               cpu_ready,
   output logic [BYTE_AW-1:0] fab_addr,
   output logic [BE_W-1:0]    fab_byteen,
   output logic               fab_read,
   output logic               fab_write,
   output logic [DATA_W-1:0]  fab_wdata,
   input  logic [DATA_W-1:0]  fab_rdata,
   input  logic               fab_waitreq
);
   // R12
   if (!(DATA_W == 8 || DATA_W == 16 || DATA_W == 32 || DATA_W == 64)) begin : g_bad_dw
      $error("ext_cpu_bridge: DATA_W must be 8, 16, 32 or 64");
   end
   // R12
   if (WORD_AW < 1) begin : g_bad_aw
      $error("ext_cpu_bridge: WORD_AW must be at least 1");
   end

   logic [BYTE_AW-1:0] byte_addr;
   logic [DATA_W-1:0]  pin_val;
   logic [DATA_W-1:0]  rdata_q;

   assign cpu_ready = ~fab_waitreq;

   xbr_addr_map #(.WORD_AW(WORD_AW), .SHIFT(SHIFT)) u_map (
      .word_addr (cpu_addr),
      .byte_addr (byte_addr)
   );

   xbr_data_pad #(.DATA_W(DATA_W)) u_pad (
      .pins      (cpu_data),
      .oe_n      (cpu_oe_n),
      .drive_val (rdata_q),
      .sampled   (pin_val)
   );

   xbr_cmd_seq #(.DATA_W(DATA_W), .BYTE_AW(BYTE_AW)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (~cpu_sel_n),
      .rd       (~cpu_rd_n),
      .wr       (~cpu_wr_n),
      .addr_in  (byte_addr),
      .be_in    (cpu_be),
      .wdata_in (pin_val),
      .waitreq  (fab_waitreq),
      .rdata_in (fab_rdata),
      .m_addr   (fab_addr),
      .m_be     (fab_byteen),
      .m_rd     (fab_read),
      .m_wr     (fab_write),
      .m_wdata  (fab_wdata),
      .rdata_q  (rdata_q)
   );

   // R4
   ready_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready != fab_waitreq);
endmodule

// File: tb/tb_ext_cpu_bridge.sv
module tb_ext_cpu_bridge;
   localparam int DW  = 32;
   localparam int AW  = 22;
   localparam int BEW = DW / 8;
   localparam int SH  = $clog2(BEW);
   localparam int FAW = AW + SH;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           sel_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, oe_n = 1'b1;
   logic [AW-1:0]  addr = '0;
   logic [BEW-1:0] be = '0;
   logic           drv = 1'b0;
   logic [DW-1:0]  drv_val = '0;
   wire  [DW-1:0]  data;
   logic           ready;
   logic [FAW-1:0] f_addr;
   logic [BEW-1:0] f_be;
   logic           f_rd, f_wr;
   logic [DW-1:0]  f_wdata;
   logic [DW-1:0]  f_rdata = '0;
   logic           f_wait = 1'b0;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;
   bit done     = 1'b0;

   assign data = drv ? drv_val : {DW{1'bz}};

   always #10 clk = ~clk;

   ext_cpu_bridge #(.DATA_W(DW), .WORD_AW(AW)) dut (
      .clk(clk), .rst_n(rst_n), .cpu_sel_n(sel_n), .cpu_rd_n(rd_n), .cpu_wr_n(wr_n),
      .cpu_oe_n(oe_n), .cpu_addr(addr), .cpu_be(be), .cpu_data(data), .cpu_ready(ready),
      .fab_addr(f_addr), .fab_byteen(f_be), .fab_read(f_rd), .fab_write(f_wr),
      .fab_wdata(f_wdata), .fab_rdata(f_rdata), .fab_waitreq(f_wait)
   );

   function automatic logic [FAW-1:0] exp_addr(input logic [AW-1:0] a);
      return FAW'(a) << SH;
   endfunction

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic idle_bus();
      sel_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; drv = 1'b0; oe_n = 1'b1;
   endtask

   task automatic txn(input bit is_wr, input logic [AW-1:0] a, input logic [BEW-1:0] b,
                      input logic [DW-1:0] d, input int waits);
      @(negedge clk);
      addr = a; be = b; sel_n = 1'b0;
      if (is_wr) begin
         wr_n = 1'b0; drv = 1'b1; drv_val = d; oe_n = 1'b1;
      end else begin
         rd_n = 1'b0; drv = 1'b0; oe_n = 1'b0;
      end
      @(negedge clk);
      check(is_wr ? (f_wr && !f_rd) : (f_rd && !f_wr), "R3", {f_rd, f_wr}, is_wr ? 64'h1 : 64'h2);
      check(f_addr == exp_addr(a), "R1", f_addr, exp_addr(a));
      check(f_be == b, "R2", f_be, b);
      if (is_wr) check(f_wdata == d, "R5", f_wdata, d);
      if (waits > 0) begin
         f_wait = 1'b1;
         #1;
         check(ready == 1'b0, "R4", ready, 0);
         for (int i = 0; i < waits; i++) begin
            @(negedge clk);
            check((is_wr ? f_wr : f_rd) && f_addr == exp_addr(a) && f_be == b,
                  "R6/R7 hold", {f_rd, f_wr}, is_wr ? 64'h1 : 64'h2);
         end
      end
      f_wait = 1'b0;
      if (!is_wr) f_rdata = d;
      #1;
      check(ready == 1'b1, "R4", ready, 1);
      @(negedge clk);
      check(!f_rd && !f_wr, "R8", {f_rd, f_wr}, 0);
      f_rdata = ~d;
      if (!is_wr) check(data == d, "R11", data, d);
      repeat (2) begin
         @(negedge clk);
         check(!f_rd && !f_wr, "R9 held strobe", {f_rd, f_wr}, 0);
      end
      rd_n = 1'b1; wr_n = 1'b1; sel_n = 1'b1; drv = 1'b0;
      @(negedge clk);
      check(!f_rd && !f_wr, "R9 release", {f_rd, f_wr}, 0);
      if (!is_wr) check(data == d, "R11 hold", data, d);
      oe_n = 1'b1;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog: actual %0d expected below 150000", cycles);
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] last_rd;
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      check(!f_rd && !f_wr, "reset R3", {f_rd, f_wr}, 0);
      check(ready == 1'b1, "reset R4", ready, 1);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 / R2 corner values
      txn(1'b1, {AW{1'b1}}, 4'b1000, 32'hDEAD_BEEF, 0);
      txn(1'b0, '0, 4'b0001, 32'h1234_5678, 0);
      // R6: long stall, no timeout
      txn(1'b0, 22'h2A5A5, 4'b1111, 32'hCAFE_F00D, 60);
      last_rd = 32'hCAFE_F00D;

      // R10: both strobes together
      @(negedge clk);
      sel_n = 1'b0; rd_n = 1'b0; wr_n = 1'b0; drv = 1'b1; drv_val = 32'h55;
      repeat (3) begin
         @(negedge clk);
         check(!f_rd && !f_wr, "R10", {f_rd, f_wr}, 0);
      end
      idle_bus();

      // R3: strobe without select
      @(negedge clk);
      rd_n = 1'b0;
      repeat (2) begin
         @(negedge clk);
         check(!f_rd && !f_wr, "R3 no select", {f_rd, f_wr}, 0);
      end
      idle_bus();

      // R11: a write does not change captured read data
      txn(1'b1, 22'h1, 4'b0011, 32'h0BAD_0BAD, 1);
      @(negedge clk);
      oe_n = 1'b0;
      @(negedge clk);
      check(data == last_rd, "R11 after write", data, last_rd);
      oe_n = 1'b1;

      for (int k = 0; k < 80; k++) begin
         logic [DW-1:0] d;
         d = $urandom;
         txn($urandom_range(0, 1), AW'($urandom), BEW'($urandom), d, $urandom_range(0, 6));
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule